// File: doc/BRIEF.md
# Latched Limit and Trip Event Register

This block keeps a sticky record of regulation-mode and protection events for a single power output. Five live condition inputs (constant-voltage mode, constant-current mode, over-voltage trip, over-current trip, and a hard trip) are watched for rising edges. Each rising edge sets its own bit in an 8-bit event register, and the bit stays set until the host reads the register. A read strobe captures the register into a read-data output and clears it in the same cycle. Any event that rises in that same cycle is still recorded after the clear, so it is not lost.

A separate 8-bit enable mask is written through a strobed write port and can always be read back. The single summary output goes high whenever an event bit and its enable bit are both set. Higher-level status logic collects this summary bit. After reset the register holds zero. On the first clock edge after reset it loads every condition that is already active, because the edge detector's history starts from zero. A supply with two outputs uses two copies of this block.

Top module: `lim_evt_reg`

## Requirements
- R1: While reset is asserted, `rd_data_o`, `en_rdata_o` and `summary_o` are all 0.
- R2: On the first clock edge after reset is released, every condition input that is high at that edge sets its event bit. With cv, ov and hard trip held high through reset, the first read returns 0x45.
- R3: The event bits are placed as follows: constant-voltage entry sets bit 0 (0x01), constant-current entry sets bit 1 (0x02), over-voltage trip sets bit 2 (0x04), over-current trip sets bit 3 (0x08), and hard trip sets bit 6 (0x40).
- R4: Bits 7, 5 and 4 of `rd_data_o` always read 0. With every condition rising, a read returns 0x4F.
- R5: A set event bit stays set after its condition input falls, until the register is read.
- R6: A condition input that stays high does not set its bit again after a read. Only a new low-to-high transition sets it.
- R7: When `rd_stb_i` is high at a clock edge, `rd_data_o` shows the register contents from before that edge, starting after the edge. It holds that value until the next read, and the register is cleared at that edge.
- R8: A condition that rises at the same edge as a read is set in the register after that edge, and the next read returns it.
- R9: `en_rdata_o` resets to 0. When `en_wr_i` is high at an edge, it takes `en_wdata_i` at that edge and holds it otherwise.
- R10: `summary_o` is high exactly when the bitwise AND of the event register and the enable mask is non-zero. With the default combinational summary, it follows the register in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cv_mode_i | input | 1 | Output is in constant-voltage regulation |
| cc_mode_i | input | 1 | Output is in constant-current regulation |
| ov_trip_i | input | 1 | Over-voltage protection has tripped |
| oc_trip_i | input | 1 | Over-current protection has tripped |
| hard_trip_i | input | 1 | Trip that only a local or power-cycle reset clears |
| rd_stb_i | input | 1 | Read-and-clear strobe, one cycle |
| rd_data_o | output | 8 | Contents captured by the last read |
| en_wr_i | input | 1 | Enable mask write strobe |
| en_wdata_i | input | 8 | Enable mask write data |
| en_rdata_o | output | 8 | Enable mask readback |
| summary_o | output | 1 | Any enabled event is pending |

## Verification
The edge assertion assumes the condition inputs are synchronous to `clk` and that no synchronizer stages are configured. The bench therefore changes conditions only on falling clock edges and uses the default zero-stage configuration. The read-capture and enable assertions assume each strobe is sampled at exactly one edge. The bench drives every strobe for one full cycle, from one falling edge to the next. A sweep covers every pair of consecutive 5-bit condition patterns, with reads and enable writes interleaved so that events and clears land in the same cycle.

// File: rtl/lim_evt_pkg.sv
package lim_evt_pkg;
   localparam int unsigned EVT_W   = 8;
   localparam int unsigned COND_N  = 5;

   // event bit positions decoded by host software
   localparam int unsigned POS_CV   = 0;
   localparam int unsigned POS_CC   = 1;
   localparam int unsigned POS_OV   = 2;
   localparam int unsigned POS_OC   = 3;
   localparam int unsigned POS_HARD = 6;

   localparam logic [EVT_W-1:0] IMPL_MASK =
      EVT_W'((1 << POS_CV) | (1 << POS_CC) | (1 << POS_OV) |
             (1 << POS_OC) | (1 << POS_HARD));

   // condition vector order: {hard, oc, ov, cc, cv}
   typedef struct packed {
      logic hard;
      logic oc;
      logic ov;
      logic cc;
      logic cv;
   } cond_t;

   function automatic logic [EVT_W-1:0] cond_to_evt(input cond_t c);
      logic [EVT_W-1:0] r;
      r           = '0;
      r[POS_CV]   = c.cv;
      r[POS_CC]   = c.cc;
      r[POS_OV]   = c.ov;
      r[POS_OC]   = c.oc;
      r[POS_HARD] = c.hard;
      return r;
   endfunction
endpackage

// File: rtl/lim_cond_sync.sv
module lim_cond_sync #(
   parameter int unsigned WIDTH  = 5,
   parameter int unsigned STAGES = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   generate
      if (STAGES == 0) begin : g_pass
         assign q_o = d_i;
      end else begin : g_sync
         logic [WIDTH-1:0] chain_q [STAGES];
         for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) begin
                  chain_q[s] <= '0;
               end else if (s == 0) begin
                  chain_q[s] <= d_i;
               end else begin
                  chain_q[s] <= chain_q[(s == 0) ? 0 : s-1];
               end
            end
         end
         assign q_o = chain_q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/lim_edge_det.sv
module lim_edge_det #(
   parameter int unsigned WIDTH = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] lvl_i,
   output logic [WIDTH-1:0] rise_o
);
   // history starts at zero so conditions active at reset release
   // appear as rising edges on the first clock
   logic [WIDTH-1:0] hist_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hist_q <= '0;
      end else begin
         hist_q <= lvl_i;
      end
   end

   assign rise_o = lvl_i & ~hist_q;
endmodule

// File: rtl/lim_evt_bank.sv
module lim_evt_bank #(
   parameter int unsigned              WIDTH     = 8,
   parameter logic [WIDTH-1:0]         IMPL_BITS = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] set_i,
   input  logic             rd_stb_i,
   output logic [WIDTH-1:0] evt_o,
   output logic [WIDTH-1:0] rd_data_o
);
   logic [WIDTH-1:0] evt_q;
   logic [WIDTH-1:0] rd_q;

   generate
      for (genvar b = 0; b < WIDTH; b++) begin : g_bit
         if (IMPL_BITS[b]) begin : g_cell
            // set wins over the clear of a same-cycle read
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) begin
                  evt_q[b] <= 1'b0;
               end else begin
                  evt_q[b] <= set_i[b] | (evt_q[b] & ~rd_stb_i);
               end
            end
         end else begin : g_rsvd
            assign evt_q[b] = 1'b0;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_q <= '0;
      end else if (rd_stb_i) begin
         rd_q <= evt_q;
      end
   end

   assign evt_o     = evt_q;
   assign rd_data_o = rd_q;
endmodule

// File: rtl/lim_en_reg.sv
module lim_en_reg #(
   parameter int unsigned WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_i,
   input  logic [WIDTH-1:0] wdata_i,
   output logic [WIDTH-1:0] q_o
);
   logic [WIDTH-1:0] mask_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= '0;
      end else if (wr_i) begin
         mask_q <= wdata_i;
      end
   end

   assign q_o = mask_q;
endmodule

// File: rtl/lim_evt_reg.sv
module lim_evt_reg #(
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned SYNC_STAGES = 0,
   parameter bit          SUM_REG     = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cv_mode_i,
   input  logic              cc_mode_i,
   input  logic              ov_trip_i,
   input  logic              oc_trip_i,
   input  logic              hard_trip_i,
   input  logic              rd_stb_i,
   output logic [DATA_W-1:0] rd_data_o,
   input  logic              en_wr_i,
   input  logic [DATA_W-1:0] en_wdata_i,
   output logic [DATA_W-1:0] en_rdata_o,
   output logic              summary_o
);
   import lim_evt_pkg::*;

   localparam int unsigned CW = COND_N;

   initial begin
      if (DATA_W != EVT_W) begin
         $fatal(1, "lim_evt_reg: DATA_W must equal %0d", EVT_W);
      end
      if (SYNC_STAGES > 4) begin
         $fatal(1, "lim_evt_reg: SYNC_STAGES above 4 not supported");
      end
   end

   cond_t            cond_raw;
   logic [CW-1:0]    cond_sync;
   logic [CW-1:0]    cond_rise;
   logic [DATA_W-1:0] set_vec;
   logic [DATA_W-1:0] evt_q;
   logic [DATA_W-1:0] en_q;
   logic              hit;

   assign cond_raw = '{hard: hard_trip_i, oc: oc_trip_i, ov: ov_trip_i,
                       cc: cc_mode_i, cv: cv_mode_i};

   lim_cond_sync #(.WIDTH(CW), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (cond_raw),
      .q_o   (cond_sync)
   );

   lim_edge_det #(.WIDTH(CW)) u_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .lvl_i  (cond_sync),
      .rise_o (cond_rise)
   );

   assign set_vec = cond_to_evt(cond_t'(cond_rise));

   lim_evt_bank #(.WIDTH(DATA_W), .IMPL_BITS(IMPL_MASK)) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_i     (set_vec),
      .rd_stb_i  (rd_stb_i),
      .evt_o     (evt_q),
      .rd_data_o (rd_data_o)
   );

   lim_en_reg #(.WIDTH(DATA_W)) u_en (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_i    (en_wr_i),
      .wdata_i (en_wdata_i),
      .q_o     (en_q)
   );

   assign en_rdata_o = en_q;
   assign hit        = |(evt_q & en_q);

   generate
      if (SUM_REG) begin : g_sum_reg
         logic sum_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sum_q <= 1'b0;
            end else begin
               sum_q <= hit;
            end
         end
         assign summary_o = sum_q;
      end else begin : g_sum_comb
         assign summary_o = hit;
      end
   endgenerate
endmodule

module lim_evt_chk #(
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned SYNC_STAGES = 0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cv_mode_i,
   input logic              hard_trip_i,
   input logic              rd_stb_i,
   input logic [DATA_W-1:0] rd_data_o,
   input logic [DATA_W-1:0] evt_q,
   input logic              en_wr_i,
   input logic [DATA_W-1:0] en_wdata_i,
   input logic [DATA_W-1:0] en_rdata_o,
   input logic              summary_o
);
   AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data_o[7] == 1'b0) && (rd_data_o[5] == 1'b0) && (rd_data_o[4] == 1'b0)); // R4

   AST_RD_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      rd_stb_i |=> (rd_data_o == $past(evt_q))); // R7

   AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_stb_i |=> $stable(rd_data_o)); // R7

   AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_stb_i |=> ((evt_q & $past(evt_q)) == $past(evt_q))); // R5

   AST_EN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      en_wr_i |=> (en_rdata_o == $past(en_wdata_i))); // R9

   AST_SUM_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      summary_o |-> (en_rdata_o != '0)); // R10

   generate
      if (SYNC_STAGES == 0) begin : g_edge_chk
         AST_CV_EDGE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(cv_mode_i) |=> evt_q[0]); // R3

         AST_HARD_EDGE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(hard_trip_i) |=> evt_q[6]); // R8
      end
   endgenerate
endmodule

bind lim_evt_reg lim_evt_chk #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cv_mode_i   (cv_mode_i),
   .hard_trip_i (hard_trip_i),
   .rd_stb_i    (rd_stb_i),
   .rd_data_o   (rd_data_o),
   .evt_q       (evt_q),
   .en_wr_i     (en_wr_i),
   .en_wdata_i  (en_wdata_i),
   .en_rdata_o  (en_rdata_o),
   .summary_o   (summary_o)
);

// File: tb/tb_lim_evt_reg.sv
`timescale 1ns/1ps
module tb_lim_evt_reg;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cv_mode_i = 1'b0, cc_mode_i = 1'b0, ov_trip_i = 1'b0;
   logic       oc_trip_i = 1'b0, hard_trip_i = 1'b0;
   logic       rd_stb_i = 1'b0;
   logic [7:0] rd_data_o;
   logic       en_wr_i = 1'b0;
   logic [7:0] en_wdata_i = '0;
   logic [7:0] en_rdata_o;
   logic       summary_o;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   // model state
   logic [4:0] prev_m;
   logic [7:0] ev_m, rd_m, en_m;

   always #4 clk = ~clk; // 125 MHz

   lim_evt_reg dut (
      .clk(clk), .rst_n(rst_n),
      .cv_mode_i(cv_mode_i), .cc_mode_i(cc_mode_i), .ov_trip_i(ov_trip_i),
      .oc_trip_i(oc_trip_i), .hard_trip_i(hard_trip_i),
      .rd_stb_i(rd_stb_i), .rd_data_o(rd_data_o),
      .en_wr_i(en_wr_i), .en_wdata_i(en_wdata_i), .en_rdata_o(en_rdata_o),
      .summary_o(summary_o)
   );

   // condition bit k -> event position per R3
   function automatic logic [7:0] expand(input logic [4:0] c);
      logic [7:0] r = 8'h00;
      if (c[0]) r = r + 8'h01;
      if (c[1]) r = r + 8'h02;
      if (c[2]) r = r + 8'h04;
      if (c[3]) r = r + 8'h08;
      if (c[4]) r = r + 8'h40;
      return r;
   endfunction

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
      end
   endtask

   task automatic drive_cond(input logic [4:0] c);
      {hard_trip_i, oc_trip_i, ov_trip_i, cc_mode_i, cv_mode_i} = c;
   endtask

   // one cycle: drive at negedge, model at posedge, compare after it
   task automatic step(input logic [4:0] c, input logic rd, input logic we,
                       input logic [7:0] wd, input string tag);
      logic [7:0] rise;
      @(negedge clk);
      drive_cond(c);
      rd_stb_i = rd; en_wr_i = we; en_wdata_i = wd;
      @(posedge clk);
      rise = expand(c & ~prev_m);
      if (rd) begin
         rd_m = ev_m;
         ev_m = rise;
      end else begin
         ev_m = ev_m | rise;
      end
      prev_m = c;
      if (we) en_m = wd;
      #2;
      chk({tag, " rd_data"}, rd_data_o, rd_m);
      chk({tag, " en_rdata"}, en_rdata_o, en_m);
      chk({tag, " summary"}, {7'd0, summary_o}, {7'd0, |(ev_m & en_m)});
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         n_tests++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      logic [7:0] pos [5];
      pos[0] = 8'h01; pos[1] = 8'h02; pos[2] = 8'h04; pos[3] = 8'h08; pos[4] = 8'h40;

      // R1: reset values with conditions applied
      drive_cond(5'b10101);
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R1 rd_data", rd_data_o, 8'h00);
      chk("R1 en_rdata", en_rdata_o, 8'h00);
      chk("R1 summary", {7'd0, summary_o}, 8'h00);

      prev_m = '0; ev_m = '0; rd_m = '0; en_m = '0;
      rst_n = 1'b1;
      // R2: power-up reload of active conditions
      step(5'b10101, 1'b0, 1'b0, 8'h00, "R2 load");
      step(5'b10101, 1'b1, 1'b0, 8'h00, "R2 read");
      chk("R2 first read", rd_data_o, 8'h45);
      // R6: steady conditions do not re-set
      step(5'b10101, 1'b1, 1'b0, 8'h00, "R6 read");
      chk("R6 steady no reset", rd_data_o, 8'h00);
      step(5'b00000, 1'b1, 1'b0, 8'h00, "R6 clear");

      // R3: bit positions
      for (int k = 0; k < 5; k++) begin
         step(5'(1 << k), 1'b0, 1'b0, 8'h00, "R3 rise");
         step(5'(1 << k), 1'b1, 1'b0, 8'h00, "R3 read");
         chk("R3 position", rd_data_o, pos[k]);
         step(5'b00000, 1'b0, 1'b0, 8'h00, "R3 fall");
      end

      // R4: all rising, reserved bits stay zero
      step(5'b11111, 1'b0, 1'b0, 8'h00, "R4 rise");
      step(5'b11111, 1'b1, 1'b0, 8'h00, "R4 read");
      chk("R4 all bits", rd_data_o, 8'h4F);
      step(5'b00000, 1'b0, 1'b0, 8'h00, "R4 fall");

      // R5: sticky after condition falls
      step(5'b01000, 1'b0, 1'b0, 8'h00, "R5 rise");
      step(5'b00000, 1'b0, 1'b0, 8'h00, "R5 fall");
      step(5'b00000, 1'b0, 1'b0, 8'h00, "R5 wait");
      step(5'b00000, 1'b1, 1'b0, 8'h00, "R5 read");
      chk("R5 sticky", rd_data_o, 8'h08);
      // R7: register cleared by that read
      step(5'b00000, 1'b1, 1'b0, 8'h00, "R7 reread");
      chk("R7 cleared", rd_data_o, 8'h00);

      // R8: event in same cycle as read survives
      step(5'b00010, 1'b1, 1'b0, 8'h00, "R8 collide");
      chk("R8 collide read old", rd_data_o, 8'h00);
      step(5'b00010, 1'b1, 1'b0, 8'h00, "R8 next read");
      chk("R8 kept event", rd_data_o, 8'h02);

      // R9: enable write and hold
      step(5'b00000, 1'b0, 1'b1, 8'hA5, "R9 write");
      chk("R9 readback", en_rdata_o, 8'hA5);
      step(5'b00000, 1'b0, 1'b0, 8'h11, "R9 hold");
      chk("R9 hold", en_rdata_o, 8'hA5);

      // R10: summary with matching and non-matching mask
      step(5'b00000, 1'b0, 1'b1, 8'h40, "R10 mask");
      step(5'b00100, 1'b0, 1'b0, 8'h00, "R10 nomatch");
      chk("R10 no match", {7'd0, summary_o}, 8'h00);
      step(5'b10100, 1'b0, 1'b0, 8'h00, "R10 match");
      chk("R10 match", {7'd0, summary_o}, 8'h01);
      step(5'b00000, 1'b1, 1'b0, 8'h00, "R10 clear");
      chk("R10 cleared", {7'd0, summary_o}, 8'h00);

      // sweep of all condition transitions: R5 R7 R8 R10
      for (int a = 0; a < 32; a++) begin
         for (int b = 0; b < 32; b++) begin
            step(5'(a), 1'b0, (b % 7) == 0, 8'((a * 37 + b) & 8'hFF), "R5 R10 sweep set");
            step(5'(b), ((a ^ b) & 1) == 1, 1'b0, 8'h00, "R7 R8 sweep rd");
         end
      end

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule